// File: doc/BRIEF.md
# Bus Error Capture Register with Lock

This block holds the 32-bit error status word for one node on a shared system bus, together with a small configuration word. Error detectors elsewhere in the node pulse one strobe per error class for a single cycle. The block turns each strobe into a sticky status bit at the same bit position.

Software reads both words through a simple CSR port. It clears status bits by writing ones to the status word. The configuration word can:
- suppress two timeout error classes;
- mask the interrupt raised for correctable write-data and read-data errors;
- enable locking on the first recorded error.

Locking freezes the status word so that the first error in a burst is preserved for diagnosis. Any status bit outside the syndrome-indicator field 20–23 locks the word when it newly sets. With lock-on-first-error enabled, every recorded event locks it. While locked, incoming strobes are dropped. The lock is released in two ways: by clearing every status bit, or by a configuration write that leaves bit 31 at zero.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the status word and the configuration word read zero, `locked_o` is low and `irq_o` is low.
- R2: While unlocked, a strobe on `err_evt_i[k]` sets status bit k on the following clock edge, and the bit stays set until software clears it.
- R3: A CSR write with `csr_sel_i` = 0 (status) clears every status bit whose write-data bit is 1 and leaves the status bits whose write-data bit is 0 unchanged.
- R4: A CSR write with `csr_sel_i` = 1 (config) stores bits 0, 1, 2, 3 and 31 of the write data. All other configuration bits read as zero.
- R5: A status bit outside positions 20–23 that becomes set locks the register (`locked_o` high on the next cycle), regardless of configuration bit 31.
- R6: With configuration bit 31 set, any recorded event locks the register, including events on bits 20–23.
- R7: While locked, error strobes have no effect on the status word.
- R8: A status write that leaves every status bit zero releases the lock. A strobe in that same cycle is recorded after the clear, and it re-locks only under R5/R6. A partial clear does not release the lock.
- R9: A configuration write with bit 31 = 0 releases the lock, even while status bits remain set.
- R10: Configuration bit 2 blocks strobe bit 3 (bank lock timeout), and configuration bit 3 blocks strobe bit 31 (data timeout). A blocked strobe neither sets a bit nor locks.
- R11: `irq_o` is high exactly while (status bit 17 is set and configuration bit 0 is clear) or (status bit 18 is set and configuration bit 1 is clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 32 | Single-cycle error strobes, one per status bit |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 1 | CSR word select: 0 status, 1 config |
| csr_wdata_i | input | 32 | CSR write data (ones clear, for status) |
| csr_rdata_o | output | 32 | Selected word, combinational |
| locked_o | output | 1 | Status word is locked |
| irq_o | output | 1 | Correctable data error interrupt level |

## Verification
A wrong lock state shows up one cycle after the next strobe. If the lock is stuck high, a fresh event is missing from the status readback. If it is stuck low, a second event appears next to the first. Both cases show up on `locked_o` right away. Every status bit position is swept with lock-on-first-error off and on. Each sweep is followed by a second event, so that a wrongly classified syndrome bit or a wrongly decoded disable bit shows up as an extra or missing status bit in that same readback. The same-cycle clear-and-strobe case and the partial-clear case separate releasing the lock too early from releasing it too late.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned SYND_LO = 20;
  localparam int unsigned SYND_HI = 23;

  localparam int unsigned ST_BANK_TMO = 3;
  localparam int unsigned ST_CWD      = 17;
  localparam int unsigned ST_CRD      = 18;
  localparam int unsigned ST_DATA_TMO = 31;

  localparam int unsigned CF_CWD_IRQ_DIS  = 0;
  localparam int unsigned CF_CRD_IRQ_DIS  = 1;
  localparam int unsigned CF_BANK_TMO_DIS = 2;
  localparam int unsigned CF_DATA_TMO_DIS = 3;
  localparam int unsigned CF_LOCK_FIRST   = 31;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CFG    = 1'b1
  } csr_sel_e;

  localparam logic [WORD_W-1:0] CFG_WR_MASK =
    (WORD_W'(1) << CF_CWD_IRQ_DIS)  | (WORD_W'(1) << CF_CRD_IRQ_DIS) |
    (WORD_W'(1) << CF_BANK_TMO_DIS) | (WORD_W'(1) << CF_DATA_TMO_DIS) |
    (WORD_W'(1) << CF_LOCK_FIRST);

  function automatic logic [WORD_W-1:0] synd_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = SYND_LO; i <= SYND_HI; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bec_cfg_reg.sv
module bec_cfg_reg
  import bec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              lock_first_nxt_o,
  output logic              lock_drop_o,
  output logic [WORD_W-1:0] evt_block_o
);
  logic [WORD_W-1:0] cfg_q, cfg_d;

  assign cfg_d = wr_i ? (wdata_i & CFG_WR_MASK) : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  // lock enable seen by this cycle's lock decision follows the write
  assign lock_first_nxt_o = cfg_d[CF_LOCK_FIRST];
  assign lock_drop_o      = wr_i && !wdata_i[CF_LOCK_FIRST];

  always_comb begin
    evt_block_o = '0;
    evt_block_o[ST_BANK_TMO] = cfg_q[CF_BANK_TMO_DIS];
    evt_block_o[ST_DATA_TMO] = cfg_q[CF_DATA_TMO_DIS];
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/bec_status_core.sv
module bec_status_core
  import bec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] evt_i,
  input  logic [WORD_W-1:0] block_i,
  input  logic              clr_wr_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  input  logic              lock_eff_i,
  output logic [WORD_W-1:0] after_clr_o,
  output logic [WORD_W-1:0] accepted_o,
  output logic [WORD_W-1:0] newly_set_o,
  output logic [WORD_W-1:0] status_o
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic st_q;
    logic kept;
    logic take;

    assign kept = st_q && !(clr_wr_i && clr_mask_i[b]);
    assign take = evt_i[b] && !block_i[b] && !lock_eff_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 1'b0;
      else         st_q <= kept | take;
    end

    assign after_clr_o[b] = kept;
    assign accepted_o[b]  = take;
    assign newly_set_o[b] = take && !kept;
    assign status_o[b]    = st_q;
  end
endmodule

// File: rtl/bec_lock_ctrl.sv
module bec_lock_ctrl
  import bec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] after_clr_i,
  input  logic              lock_drop_i,
  input  logic              lock_first_i,
  input  logic [WORD_W-1:0] accepted_i,
  input  logic [WORD_W-1:0] newly_set_i,
  output logic              lock_eff_o,
  output logic              locked_o
);
  localparam logic [WORD_W-1:0] HARD_MASK = ~synd_mask();

  logic lock_q, release_now, lock_set;

  // a full clear or dropped enable releases before this cycle's events
  assign release_now = (after_clr_i == '0) || lock_drop_i;
  assign lock_eff_o  = lock_q && !release_now;

  assign lock_set = (lock_first_i && (accepted_i != '0)) ||
                    ((newly_set_i & HARD_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_eff_o || lock_set;
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/bec_irq.sv
module bec_irq
  import bec_pkg::*;
(
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic              irq_o
);
  assign irq_o = (status_i[ST_CWD] && !cfg_i[CF_CWD_IRQ_DIS]) ||
                 (status_i[ST_CRD] && !cfg_i[CF_CRD_IRQ_DIS]);
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] err_evt_i,
  input  logic              csr_we_i,
  input  logic              csr_sel_i,
  input  logic [WORD_W-1:0] csr_wdata_i,
  output logic [WORD_W-1:0] csr_rdata_o,
  output logic              locked_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] status_q, cfg_q, evt_block;
  logic [WORD_W-1:0] after_clr, accepted, newly_set;
  logic              st_wr, cf_wr, lock_first_nxt, lock_drop, lock_eff;

  assign st_wr = csr_we_i && (csr_sel_e'(csr_sel_i) == SEL_STATUS);
  assign cf_wr = csr_we_i && (csr_sel_e'(csr_sel_i) == SEL_CFG);

  bec_cfg_reg u_cfg (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_i             (cf_wr),
    .wdata_i          (csr_wdata_i),
    .cfg_o            (cfg_q),
    .lock_first_nxt_o (lock_first_nxt),
    .lock_drop_o      (lock_drop),
    .evt_block_o      (evt_block)
  );

  bec_status_core u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (err_evt_i),
    .block_i     (evt_block),
    .clr_wr_i    (st_wr),
    .clr_mask_i  (csr_wdata_i),
    .lock_eff_i  (lock_eff),
    .after_clr_o (after_clr),
    .accepted_o  (accepted),
    .newly_set_o (newly_set),
    .status_o    (status_q)
  );

  bec_lock_ctrl u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .after_clr_i  (after_clr),
    .lock_drop_i  (lock_drop),
    .lock_first_i (lock_first_nxt),
    .accepted_i   (accepted),
    .newly_set_i  (newly_set),
    .lock_eff_o   (lock_eff),
    .locked_o     (locked_o)
  );

  bec_irq u_irq (
    .status_i (status_q),
    .cfg_i    (cfg_q),
    .irq_o    (irq_o)
  );

  assign csr_rdata_o = csr_sel_i ? cfg_q : status_q;
endmodule

// File: rtl/bec_checker.sv
module bec_checker
  import bec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] err_evt_i,
  input logic              csr_we_i,
  input logic              csr_sel_i,
  input logic [WORD_W-1:0] csr_wdata_i,
  input logic [WORD_W-1:0] status_q,
  input logic [WORD_W-1:0] cfg_q,
  input logic              locked_o,
  input logic              irq_o
);
  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_sel_i) |=>
      ((status_q & $past(csr_wdata_i) & ~$past(err_evt_i)) == '0));

  assert_hard_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && !csr_we_i && err_evt_i[0]) |=> locked_o);

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !csr_we_i) |=> $stable(status_q));

  assert_tmo_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[CF_DATA_TMO_DIS] && !status_q[ST_DATA_TMO]) |=> !status_q[ST_DATA_TMO]);

  assert_irq_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_q[ST_CWD] && !status_q[ST_CRD]) |-> !irq_o);

  assert_cfg_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q & ~CFG_WR_MASK) == '0);
endmodule

bind bus_err_capture bec_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_evt_i   (err_evt_i),
  .csr_we_i    (csr_we_i),
  .csr_sel_i   (csr_sel_i),
  .csr_wdata_i (csr_wdata_i),
  .status_q    (status_q),
  .cfg_q       (cfg_q),
  .locked_o    (locked_o),
  .irq_o       (irq_o)
);

// File: tb/bus_err_capture_tb_top.sv
module bus_err_capture_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] err_evt_i = '0;
  logic        csr_we_i = 1'b0;
  logic        csr_sel_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        locked_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  bus_err_capture dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_evt_i   (err_evt_i),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .locked_o    (locked_o),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive for one edge, then return at the following negedge
  task automatic drive(input logic [31:0] e, input logic we, input logic sel,
                       input logic [31:0] wd);
    err_evt_i = e; csr_we_i = we; csr_sel_i = sel; csr_wdata_i = wd;
    @(negedge clk_i);
    err_evt_i = '0; csr_we_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    csr_sel_i = sel;
    #1ns;
    v = csr_rdata_o;
  endtask

  task automatic pulse(input int k);
    drive(32'd1 << k, 1'b0, 1'b0, '0);
  endtask

  task automatic clear_all();
    drive('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic set_cfg(input logic [31:0] c);
    drive('0, 1'b1, 1'b1, c);
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_st;
    logic        exp_lk;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    rd(1'b0, v); chk("R1 status", v, '0);
    rd(1'b1, v); chk("R1 cfg", v, '0);
    chk("R1 lock", {31'd0, locked_o}, '0);
    chk("R1 irq", {31'd0, irq_o}, '0);

    // sweep with lock-on-first off
    for (int k = 0; k < 32; k++) begin
      int j;
      j = (k + 7) % 32;
      pulse(k);
      exp_lk = !(k >= 20 && k <= 23);
      rd(1'b0, v); chk("R2 sticky set", v, 32'd1 << k);
      chk("R5 lock on hard bit", {31'd0, locked_o}, {31'd0, exp_lk});
      pulse(j);
      exp_st = exp_lk ? (32'd1 << k) : ((32'd1 << k) | (32'd1 << j));
      rd(1'b0, v); chk("R7 second event", v, exp_st);
      chk("R11 irq", {31'd0, irq_o}, {31'd0, exp_st[17] | exp_st[18]});
      clear_all();
      rd(1'b0, v); chk("R8 full clear", v, '0);
      chk("R8 unlock", {31'd0, locked_o}, '0);
    end

    // sweep with lock-on-first on
    set_cfg(32'h8000_0000);
    for (int k = 0; k < 32; k++) begin
      pulse(k);
      chk("R6 lock any", {31'd0, locked_o}, 32'd1);
      pulse((k + 3) % 32);
      rd(1'b0, v); chk("R7 ignored while locked", v, 32'd1 << k);
      clear_all();
      chk("R8 unlock lof", {31'd0, locked_o}, '0);
    end

    // R4 config writable field
    set_cfg(32'hFFFF_FFFF);
    rd(1'b1, v); chk("R4 cfg mask", v, 32'h8000_000F);
    set_cfg(32'h0000_0005);
    rd(1'b1, v); chk("R4 cfg value", v, 32'h0000_0005);
    set_cfg('0);

    // R10 blocked timeouts
    set_cfg(32'd1 << 2);
    pulse(3);
    rd(1'b0, v); chk("R10 bank tmo blocked", v, '0);
    chk("R10 no lock", {31'd0, locked_o}, '0);
    pulse(31);
    rd(1'b0, v); chk("R10 other bit kept", v, 32'h8000_0000);
    clear_all();
    set_cfg(32'd1 << 3);
    pulse(31);
    rd(1'b0, v); chk("R10 data tmo blocked", v, '0);
    chk("R10 no lock 2", {31'd0, locked_o}, '0);
    pulse(3);
    rd(1'b0, v); chk("R10 bank tmo allowed", v, 32'd8);
    clear_all();

    // R11 irq masking
    for (int m = 0; m < 4; m++) begin
      set_cfg(32'(m));
      drive((32'd1 << 17) | (32'd1 << 18), 1'b0, 1'b0, '0);
      chk("R11 both", {31'd0, irq_o}, {31'd0, !(m[0] && m[1])});
      clear_all();
      pulse(17);
      chk("R11 cwd", {31'd0, irq_o}, {31'd0, !m[0]});
      clear_all();
      pulse(18);
      chk("R11 crd", {31'd0, irq_o}, {31'd0, !m[1]});
      clear_all();
    end
    set_cfg('0);

    // R3 partial clear, R8 partial clear keeps lock
    pulse(20); pulse(21);
    drive('0, 1'b1, 1'b0, (32'd1 << 20));
    rd(1'b0, v); chk("R3 w1c partial", v, 32'd1 << 21);
    clear_all();
    drive((32'd1 << 5) | (32'd1 << 6), 1'b0, 1'b0, '0);
    drive('0, 1'b1, 1'b0, 32'd1 << 5);
    rd(1'b0, v); chk("R3 keep zero bits", v, 32'd1 << 6);
    chk("R8 partial keeps lock", {31'd0, locked_o}, 32'd1);
    pulse(7);
    rd(1'b0, v); chk("R7 still frozen", v, 32'd1 << 6);

    // R8 same-cycle clear and event
    drive(32'd1 << 22, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R8 event after clear", v, 32'd1 << 22);
    chk("R8 syndrome no relock", {31'd0, locked_o}, '0);
    clear_all();
    pulse(5);
    drive(32'd1 << 9, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R8 hard event after clear", v, 32'd1 << 9);
    chk("R8 relock", {31'd0, locked_o}, 32'd1);
    clear_all();

    // R9 release by dropping lock-on-first
    set_cfg(32'h8000_0000);
    pulse(20);
    chk("R6 syndrome lock", {31'd0, locked_o}, 32'd1);
    set_cfg('0);
    chk("R9 release", {31'd0, locked_o}, '0);
    pulse(21);
    rd(1'b0, v); chk("R9 record after release", v, (32'd1 << 20) | (32'd1 << 21));
    chk("R9 stays unlocked", {31'd0, locked_o}, '0);
    clear_all();
    pulse(5);
    set_cfg('0);
    chk("R9 release hard lock", {31'd0, locked_o}, '0);
    pulse(9);
    rd(1'b0, v); chk("R9 recorded", v, (32'd1 << 5) | (32'd1 << 9));
    chk("R5 relock", {31'd0, locked_o}, 32'd1);
    clear_all();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule